// File: doc/BRIEF.md
# Flash Sequencing Status Register

This block holds the 16-bit status word of a hardware-sequenced SPI flash controller. It decodes at offset 04h on a simple register bus and has no wait states. It tracks whether a flash cycle is running. It records sticky error and completion flags, which software clears by writing ones to them. It also holds a lock-down flag that software can set but only reset can clear. Other program registers use this lock flag to block their own writes.

The companion control register sends a go request. The block accepts the request and starts a cycle only under three conditions: the flash descriptor is valid, no cycle error is pending, and no cycle is already running. Otherwise it rejects the request and raises the cycle error. The SPI cycle engine signals the end of a cycle with a pulse, which clears the busy flag and sets the done flag. Protection and direct-access violations are detected elsewhere and arrive as single-cycle pulses that the block logs. The descriptor-valid flag, the override strap and the erase-size code are reported as live values.

Top module: `flash_seq_status`

## Requirements
- R1: After reset, read data at offset 04h is 0000h when `desc_ok`, `ovr_strap` and `erase_sz` are all 0, and both `busy` and `lock` are 0.
- R2: The word read at offset 04h is laid out as follows. Bit 14 reflects `desc_ok` and bit 13 reflects `ovr_strap` (0 means override active, 1 means no override). Bits 4:3 carry `erase_sz`, coded 00 = 256 B, 01 = 4 KB, 10 = reserved, 11 = 64 KB. Bits 12:6 read 0. Any other address reads 0000h.
- R3: Writing a 1 to bit 15 at offset 04h sets the lock flag, which appears on `lock` and as read bit 15. Writing 0 to that bit does not clear it. Only reset clears it.
- R4: A go request starts a cycle when three conditions hold: `desc_ok` is 1, cycle error (bit 1) is 0, and busy is 0. In that case `cyc_start` is high in the same cycle and busy (bit 5 and `busy`) is 1 from the next cycle. A `cyc_done` pulse returns busy to 0.
- R5: A go request while `desc_ok` is 0 does not start a cycle and sets cycle error (bit 1).
- R6: A go request while cycle error is already set, or while busy, does not start a cycle. It leaves cycle error set and does not change busy.
- R7: A `cyc_reg_wr` pulse while busy sets cycle error. The same pulse while idle changes nothing.
- R8: A `prot_viol` pulse sets cycle error (bit 1).
- R9: A `dir_viol` pulse sets the access-error log (bit 2).
- R10: A `cyc_done` pulse sets the cycle-done flag (bit 0).
- R11: At offset 04h, writing a 1 to bit 2, 1 or 0 clears that flag. Writing a 0 leaves it unchanged. A write to any other address changes none of them.
- R12: If a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, zero when not selected |
| go_req | input | 1 | Go request pulse from the control register |
| cyc_done | input | 1 | Cycle-complete pulse from the SPI engine |
| desc_ok | input | 1 | Flash descriptor signature found |
| ovr_strap | input | 1 | Descriptor override strap level |
| erase_sz | input | 2 | Erase sector size code |
| prot_viol | input | 1 | Program-register access blocked by protection |
| dir_viol | input | 1 | Direct-access security violation |
| cyc_reg_wr | input | 1 | A cycle register was written |
| cyc_start | output | 1 | Accepted go request, launches the SPI cycle |
| busy | output | 1 | Cycle in progress |
| lock | output | 1 | Lock-down of the program registers |

## Verification
Each sticky flag can receive a hardware set event and a software clear in the same cycle. The bench forces this overlap by raising the violation pulse, the done pulse, or a rejected go request at the same clock edge as a write of ones to that flag. It then checks that the flag reads back 1. The go request can also coincide with an existing error or an active cycle. The bench sweeps every combination of descriptor-valid, preset error and preset busy, and compares the start pulse and the resulting busy and error bits with values it derives from R4 to R6.

// File: rtl/fss_pkg.sv
// Package: field positions and widths shared by the flash status register.
// Assumes a 16-bit register word; positions are fixed because software
// decodes them.
package fss_pkg;
    localparam int REG_W      = 16;
    localparam int N_STICKY   = 3;   // done, cycle error, access-error log
    localparam int POS_LOCK   = 15;
    localparam int POS_DESC   = 14;
    localparam int POS_STRAP  = 13;
    localparam int POS_BUSY   = 5;
    localparam int POS_ERASE  = 3;
    localparam int ERASE_W    = 2;
    localparam int POS_AEL    = 2;
    localparam int POS_CERR   = 1;
    localparam int POS_DONE   = 0;
endpackage

// File: rtl/fss_sticky.sv
// Module: vector of sticky flags, each set by hardware, cleared by write-one.
// Assumes set and clear are single-cycle qualified strobes; set wins over
// clear when both hit one flag in the same cycle.
module fss_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] q_r;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            // Hold one flag: reset to 0, set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)          q_r[g] <= 1'b0;
                else if (set_i[g])   q_r[g] <= 1'b1;
                else if (clr_i[g])   q_r[g] <= 1'b0;
            end
        end
    endgenerate

    assign q_o = q_r;
endmodule

// File: rtl/fss_lock.sv
// Module: set-once lock flag.
// Assumes only the synchronous reset may clear it; the set strobe is already
// qualified by address and write data.
module fss_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic lock_o
);
    logic lock_r;

    // Latch the lock on request; nothing but reset releases it.
    always_ff @(posedge clk) begin
        if (!rst_n)     lock_r <= 1'b0;
        else if (set_i) lock_r <= 1'b1;
    end

    assign lock_o = lock_r;
endmodule

// File: rtl/fss_cycle_track.sv
// Module: accepts or rejects go requests and tracks the busy state.
// Assumes go, done and register-write inputs are single-cycle pulses and
// that err_i is the current registered cycle-error flag.
module fss_cycle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic desc_ok_i,
    input  logic err_i,
    input  logic reg_wr_i,
    input  logic done_i,
    output logic start_o,
    output logic busy_o,
    output logic err_set_o
);
    logic busy_r;

    // Decide acceptance of a go request and the error it may raise.
    always_comb begin
        start_o   = go_i && desc_ok_i && !err_i && !busy_r;
        err_set_o = (go_i && !start_o) || (reg_wr_i && busy_r);
    end

    // Busy rises on an accepted start and falls on cycle completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_r <= 1'b0;
        else if (start_o) busy_r <= 1'b1;
        else if (done_i)  busy_r <= 1'b0;
    end

    assign busy_o = busy_r;
endmodule

// File: rtl/flash_seq_status.sv
// Module: 16-bit status register of a hardware-sequenced SPI flash
// controller. Decodes one bus offset, combines sticky flags, the lock, the
// busy tracker and live status inputs into the read word.
// Assumes a single-cycle write strobe and combinational read data.
module flash_seq_status
    import fss_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h04
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic                  go_req,
    input  logic                  cyc_done,
    input  logic                  desc_ok,
    input  logic                  ovr_strap,
    input  logic [ERASE_W-1:0]    erase_sz,
    input  logic                  prot_viol,
    input  logic                  dir_viol,
    input  logic                  cyc_reg_wr,
    output logic                  cyc_start,
    output logic                  busy,
    output logic                  lock
);
    logic                sel;
    logic                wr_hit;
    logic [N_STICKY-1:0] sticky_set;
    logic [N_STICKY-1:0] sticky_clr;
    logic [N_STICKY-1:0] sticky_q;
    logic                trk_err_set;
    logic                done_q;
    logic                cerr_q;
    logic                ael_q;
    logic                unused_wdata;

    // Decode the register offset and qualify writes.
    always_comb begin
        sel    = (bus_addr == REG_OFFSET);
        wr_hit = bus_wr && sel;
    end

    assign unused_wdata = ^bus_wdata[POS_LOCK-1:POS_AEL+1];

    // Route hardware set events and software clears to the sticky flags.
    always_comb begin
        sticky_set           = '0;
        sticky_set[POS_DONE] = cyc_done;
        sticky_set[POS_CERR] = prot_viol || trk_err_set;
        sticky_set[POS_AEL]  = dir_viol;
        sticky_clr           = wr_hit ? bus_wdata[N_STICKY-1:0] : '0;
    end

    fss_sticky #(.N(N_STICKY)) i_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (sticky_set),
        .clr_i (sticky_clr),
        .q_o   (sticky_q)
    );

    assign done_q = sticky_q[POS_DONE];
    assign cerr_q = sticky_q[POS_CERR];
    assign ael_q  = sticky_q[POS_AEL];

    fss_lock i_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wr_hit && bus_wdata[POS_LOCK]),
        .lock_o (lock)
    );

    fss_cycle_track i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go_req),
        .desc_ok_i (desc_ok),
        .err_i     (cerr_q),
        .reg_wr_i  (cyc_reg_wr),
        .done_i    (cyc_done),
        .start_o   (cyc_start),
        .busy_o    (busy),
        .err_set_o (trk_err_set)
    );

    // Assemble the read word; unselected reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (sel) begin
            bus_rdata[POS_LOCK]                    = lock;
            bus_rdata[POS_DESC]                    = desc_ok;
            bus_rdata[POS_STRAP]                   = ovr_strap;
            bus_rdata[POS_BUSY]                    = busy;
            bus_rdata[POS_ERASE+ERASE_W-1:POS_ERASE] = erase_sz;
            bus_rdata[POS_AEL]                     = ael_q;
            bus_rdata[POS_CERR]                    = cerr_q;
            bus_rdata[POS_DONE]                    = done_q;
        end
    end
endmodule

// File: rtl/fss_checker.sv
// Module: concurrent assertions for flash_seq_status, attached by bind.
// Assumes it observes the top's ports and its registered flag outputs.
module fss_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        go_req,
    input logic        desc_ok,
    input logic        cyc_done,
    input logic        prot_viol,
    input logic        dir_viol,
    input logic        cyc_reg_wr,
    input logic        cyc_start,
    input logic        busy,
    input logic        lock,
    input logic        cerr,
    input logic        ael,
    input logic        done,
    input logic [15:0] rdata
);
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);
    a_r4_start_guard: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (desc_ok && !busy && !cerr));
    a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> busy);
    a_r4_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !cyc_start) |=> !busy);
    a_r5_nodesc_error: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !desc_ok) |=> cerr);
    a_r6_busy_go_error: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && busy) |=> cerr);
    a_r7_reg_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_reg_wr && busy) |=> cerr);
    a_r8_prot_error: assert property (@(posedge clk) disable iff (!rst_n)
        prot_viol |=> cerr);
    a_r9_access_log: assert property (@(posedge clk) disable iff (!rst_n)
        dir_viol |=> ael);
    a_r10_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> done);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[12:6] == 7'd0);
endmodule

bind flash_seq_status fss_checker i_fss_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_req     (go_req),
    .desc_ok    (desc_ok),
    .cyc_done   (cyc_done),
    .prot_viol  (prot_viol),
    .dir_viol   (dir_viol),
    .cyc_reg_wr (cyc_reg_wr),
    .cyc_start  (cyc_start),
    .busy       (busy),
    .lock       (lock),
    .cerr       (cerr_q),
    .ael        (ael_q),
    .done       (done_q),
    .rdata      (bus_rdata)
);

// File: tb/test_flash_seq_status.sv
module test_flash_seq_status;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h04;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        go_req = 1'b0, cyc_done = 1'b0, desc_ok = 1'b0, ovr_strap = 1'b0;
    logic [1:0]  erase_sz = 2'b00;
    logic        prot_viol = 1'b0, dir_viol = 1'b0, cyc_reg_wr = 1'b0;
    logic        cyc_start, busy, lock;
    int          n_chk = 0;
    int          n_fail = 0;

    flash_seq_status i_flash_seq_status (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .go_req(go_req),
        .cyc_done(cyc_done), .desc_ok(desc_ok), .ovr_strap(ovr_strap),
        .erase_sz(erase_sz), .prot_viol(prot_viol), .dir_viol(dir_viol),
        .cyc_reg_wr(cyc_reg_wr), .cyc_start(cyc_start), .busy(busy), .lock(lock)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and drop all pulses.
    task automatic tick();
        @(negedge clk);
        go_req = 0; cyc_done = 0; prot_viol = 0; dir_viol = 0;
        cyc_reg_wr = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 0; tick(); tick(); rst_n = 1;
    endtask

    task automatic wr(input logic [15:0] d);
        bus_wr = 1; bus_wdata = d; tick();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 rdata", bus_rdata, 16'h0000);
        chk("R1 busy/lock", {14'd0, busy, lock}, 16'h0000);

        // R2 live fields over all combinations, and unselected address
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 2; s++)
                for (int e = 0; e < 4; e++) begin
                    desc_ok = d[0]; ovr_strap = s[0]; erase_sz = e[1:0];
                    #1;
                    chk("R2 layout", bus_rdata, 16'((d << 14) | (s << 13) | (e << 3)));
                    bus_addr = 8'h08; #1;
                    chk("R2 other addr", bus_rdata, 16'h0000);
                    bus_addr = 8'h04;
                end
        desc_ok = 0; ovr_strap = 0; erase_sz = 0;

        // R3 lock set, not cleared by write, cleared by reset
        wr(16'h8000);
        chk("R3 lock set", {bus_rdata[15], 14'd0, lock}, 16'h8001);
        wr(16'h0000);
        chk("R3 lock held", {bus_rdata[15], 14'd0, lock}, 16'h8001);
        do_reset();
        chk("R3 lock reset", {15'd0, lock}, 16'h0000);

        // R4 R5 R6 go request against desc_ok, preset error, preset busy
        for (int d = 0; d < 2; d++)
            for (int e = 0; e < 2; e++)
                for (int b = 0; b < 2; b++) begin
                    do_reset();
                    if (b != 0) begin desc_ok = 1; go_req = 1; tick(); end
                    if (e != 0) begin prot_viol = 1; tick(); end
                    desc_ok = d[0]; go_req = 1; #1;
                    chk("R4 R5 R6 start", {15'd0, cyc_start},
                        16'((d == 1 && e == 0 && b == 0) ? 1 : 0));
                    tick();
                    chk("R4 R5 R6 status", bus_rdata,
                        16'((d << 14)
                            | ((b == 1 || (d == 1 && e == 0)) ? 16'h20 : 16'h0)
                            | ((e == 1 || d == 0 || b == 1) ? 16'h2 : 16'h0)));
                end

        // R4 completion, R10 done flag
        do_reset();
        desc_ok = 1; go_req = 1; tick();
        chk("R4 busy pin", {15'd0, busy}, 16'h0001);
        cyc_done = 1; tick();
        chk("R4 R10 done", bus_rdata, 16'h4001);
        chk("R4 busy cleared", {15'd0, busy}, 16'h0000);

        // R7 cycle register write, idle then busy
        do_reset();
        cyc_reg_wr = 1; tick();
        chk("R7 idle", bus_rdata, 16'h4000);
        go_req = 1; tick();
        cyc_reg_wr = 1; tick();
        chk("R7 busy", bus_rdata, 16'h4022);
        desc_ok = 0;

        // R8 R9 R10 then R11 clear masks
        for (int m = 0; m < 8; m++) begin
            do_reset();
            prot_viol = 1; tick();
            chk("R8 prot", bus_rdata, 16'h0002);
            dir_viol = 1; tick();
            chk("R9 ael", bus_rdata, 16'h0006);
            cyc_done = 1; tick();
            chk("R10 done", bus_rdata, 16'h0007);
            wr(16'(m));
            chk("R11 w1c mask", bus_rdata, 16'(7 & ~m));
        end
        do_reset();
        prot_viol = 1; dir_viol = 1; cyc_done = 1; tick();
        bus_addr = 8'h10; wr(16'h0007); bus_addr = 8'h04; #1;
        chk("R11 other addr", bus_rdata, 16'h0007);

        // R12 set wins over clear on the same flag
        for (int i = 0; i < 3; i++) begin
            do_reset();
            cyc_done  = (i == 0);
            prot_viol = (i == 1);
            dir_viol  = (i == 2);
            wr(16'(1 << i));
            chk("R12 set priority", bus_rdata, 16'(1 << i));
        end
        do_reset();
        go_req = 1; wr(16'h0002);
        chk("R12 rejected go vs clear", bus_rdata, 16'h0002);

        summary();
        $finish;
    end
endmodule